// File: doc/BRIEF.md
# Issue-Queue Reconfiguration Monitor

This block watches a reconfigurable issue queue over fixed windows of cycles and decides, once per window, whether the queue should fold into fewer and deeper FIFOs or unfold into more and shallower ones. Every cycle it takes counts of issued, committed, ready-but-stalled and ready instructions, plus the current queue occupancy. It sums these counts over the window. At the last cycle of each window it compares the totals with a set of fixed-point thresholds and with history kept from earlier windows.

Level 0 is the widest configuration: 64 single-entry FIFOs. Each step up halves the FIFO count and doubles the depth, so level k means 64>>k FIFOs. The queue logic reads `level` and reconfigures itself when `change` pulses. `cause` reports which rule decided the last window. Every percentage and fractional-rate test is a cross-multiplication against the window length, which is a power of two, so the block has no divider.

Top module: `iq_window_monitor`

## Requirements
- R1: A window is 2^WIN_BITS cycles long, counted from the first clock edge after reset is released. `level` and `cause` change only at the edge that closes a window. After reset, `level`, `cause` and `change` are all 0.
- R2: `level` stays within 0..MAX_LEVEL and moves by exactly one step per window. A shrink decision raises it by one and a grow decision lowers it by one.
- R3: `change` is high for exactly one cycle, in the cycle after a window closes, and only when that window moved `level`.
- R4: Let I, C, S, R be the window totals of issued, committed, stalled and ready instructions, and W the window length. Shrink rules, highest priority first, with their `cause` codes: code 4 when I > C + W; code 5 when 100·S < 3·R; code 6 when issue rate is below the level-dependent threshold of R5; code 7 when occupancy is low per R9; code 8 when the average issue rate exceeds the current one per R5.
- R5: Code 6 fires when 10·I < (27 − 2·level)·W, so the 2.7 rate threshold drops by 0.2 per level. Code 8 fires when 100·(Aᵢ − I) > 15·(level+1)·W, so the 0.15 margin grows by 0.15 per level.
- R6: Grow rules, highest priority first: code 1 when 100·I < 92·P, with P the previous window's I; code 2 when 100·I < 94·F, with F the I of the last window run at level 0; code 3 when 100·S > 15·R.
- R7: If any grow rule holds, the block grows, even when shrink rules also hold. `cause` takes the code of the highest-priority rule in the set that won, or 0 when no rule holds.
- R8: A grow decision at level 0, or a shrink decision at MAX_LEVEL, leaves `level` unchanged and gives no `change` pulse. `cause` still reports the rule.
- R9: At each window close the block stores P and, if the window ran at level 0, F. It updates two running averages as A ← A − (A>>AVG_SH) + (T>>AVG_SH): Aᵢ from I, and Aₒ from the occupancy total O. Code 7 fires when 5·O < Aₒ. All history is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_cnt | input | CNT_W | Instructions issued this cycle |
| commit_cnt | input | CNT_W | Instructions committed this cycle |
| stall_cnt | input | CNT_W | Ready instructions not issued this cycle |
| ready_cnt | input | CNT_W | Ready instructions this cycle |
| occupancy | input | OCC_W | Valid queue entries this cycle |
| level | output | LVL_W | Configuration level; 64>>level FIFOs |
| change | output | 1 | One-cycle pulse when level moves |
| cause | output | 4 | Code of the rule that decided the last window |

## Verification
The hardest outcome to reach is the code-8 shrink. It needs the running issue average to sit clearly above the current rate. At the same time, the drop must stay small enough that neither grow rule fires, since both compare against recent windows. The stimulus gets there with twenty windows at a steady high rate, which lets the average settle, followed by a window that dips by about 5.5%. The level-shifted rate threshold is reached by holding a fractional rate of 2.4 for several windows. The stimulus produces that fraction by adding one extra issue in the first 410 cycles of each window, so the threshold in force changes from level to level while the input stays the same.

// File: rtl/iq_window_monitor.sv
module iq_window_monitor #(
  parameter int WIN_BITS  = 10,
  parameter int CNT_W     = 4,
  parameter int OCC_W     = 7,
  parameter int MAX_LEVEL = 3,
  parameter int AVG_SH    = 2,
  localparam int LVL_W    = (MAX_LEVEL < 2) ? 1 : $clog2(MAX_LEVEL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] issue_cnt,
  input  logic [CNT_W-1:0] commit_cnt,
  input  logic [CNT_W-1:0] stall_cnt,
  input  logic [CNT_W-1:0] ready_cnt,
  input  logic [OCC_W-1:0] occupancy,
  output logic [LVL_W-1:0] level,
  output logic             change,
  output logic [3:0]       cause
);
  localparam int IW = CNT_W + WIN_BITS;
  localparam int OW = OCC_W + WIN_BITS;
  localparam int MW = IW + 8 + LVL_W;
  localparam int QW = OW + 3;

  logic [WIN_BITS-1:0] win_cnt;
  logic [IW-1:0] acc_i, acc_c, acc_s, acc_r;
  logic [IW-1:0] prev_i, full_i, avg_i;
  logic [OW-1:0] acc_o, avg_o;
  logic [3:0]    cause_nx;
  logic [LVL_W-1:0] lvl_nx;
  logic [5:0]    rate_th;

  wire last = &win_cnt;

  wire [IW-1:0] tot_i = acc_i + IW'(issue_cnt);
  wire [IW-1:0] tot_c = acc_c + IW'(commit_cnt);
  wire [IW-1:0] tot_s = acc_s + IW'(stall_cnt);
  wire [IW-1:0] tot_r = acc_r + IW'(ready_cnt);
  wire [OW-1:0] tot_o = acc_o + OW'(occupancy);

  wire [MW-1:0] wnd  = MW'(1) << WIN_BITS;
  wire [MW-1:0] i100 = MW'(tot_i) * MW'(100);
  wire [MW-1:0] s100 = MW'(tot_s) * MW'(100);

  assign rate_th = (32'(level) >= 32'd14) ? 6'd0 : 6'(32'd27 - 32'(level) * 32'd2);

  wire g1 = i100 < MW'(prev_i) * MW'(92);
  wire g2 = i100 < MW'(full_i) * MW'(94);
  wire g3 = s100 > MW'(tot_r) * MW'(15);

  wire s1 = MW'(tot_i) > MW'(tot_c) + wnd;
  wire s2 = s100 < MW'(tot_r) * MW'(3);
  wire s3 = MW'(tot_i) * MW'(10) < (MW'(rate_th) << WIN_BITS);
  wire s4 = QW'(tot_o) * QW'(5) < QW'(avg_o);
  wire s5 = MW'(avg_i) * MW'(100) > i100 + (((MW'(level) + MW'(1)) * MW'(15)) << WIN_BITS);

  wire grow   = g1 | g2 | g3;
  wire shrink = s1 | s2 | s3 | s4 | s5;

  always_comb begin
    if      (g1) cause_nx = 4'd1;
    else if (g2) cause_nx = 4'd2;
    else if (g3) cause_nx = 4'd3;
    else if (s1) cause_nx = 4'd4;
    else if (s2) cause_nx = 4'd5;
    else if (s3) cause_nx = 4'd6;
    else if (s4) cause_nx = 4'd7;
    else if (s5) cause_nx = 4'd8;
    else         cause_nx = 4'd0;
  end

  always_comb begin
    lvl_nx = level;
    if (grow) begin
      if (level != '0) lvl_nx = level - 1'b1;
    end else if (shrink) begin
      if (level != LVL_W'(MAX_LEVEL)) lvl_nx = level + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
      acc_i   <= '0;
      acc_c   <= '0;
      acc_s   <= '0;
      acc_r   <= '0;
      acc_o   <= '0;
      prev_i  <= '0;
      full_i  <= '0;
      avg_i   <= '0;
      avg_o   <= '0;
      level   <= '0;
      cause   <= '0;
      change  <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      change  <= 1'b0;
      if (last) begin
        acc_i  <= '0;
        acc_c  <= '0;
        acc_s  <= '0;
        acc_r  <= '0;
        acc_o  <= '0;
        level  <= lvl_nx;
        cause  <= cause_nx;
        change <= (lvl_nx != level);
        prev_i <= tot_i;
        if (level == '0) full_i <= tot_i;
        avg_i  <= avg_i - (avg_i >> AVG_SH) + (tot_i >> AVG_SH);
        avg_o  <= avg_o - (avg_o >> AVG_SH) + (tot_o >> AVG_SH);
      end else begin
        acc_i  <= tot_i;
        acc_c  <= tot_c;
        acc_s  <= tot_s;
        acc_r  <= tot_r;
        acc_o  <= tot_o;
      end
    end
  end
endmodule

// File: rtl/iq_window_monitor_chk.sv
module iq_window_monitor_chk #(
  parameter int WIN_BITS  = 10,
  parameter int MAX_LEVEL = 3,
  localparam int LVL_W    = (MAX_LEVEL < 2) ? 1 : $clog2(MAX_LEVEL + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [LVL_W-1:0]    level,
  input logic                change,
  input logic [3:0]          cause,
  input logic [WIN_BITS-1:0] win_cnt
);
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= MAX_LEVEL);

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |->
      (32'(level) == 32'($past(level)) + 1 || 32'(level) + 1 == 32'($past(level))));

  a_r1_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level) || cause != $past(cause)) |-> (&$past(win_cnt)));

  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> !change);

  a_r3_pulse_moves: assert property (@(posedge clk) disable iff (!rst_n)
    change |-> (level != $past(level)));

  a_r3_move_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> change);

  a_r7_grow_code: assert property (@(posedge clk) disable iff (!rst_n)
    (change && level < $past(level)) |-> (cause >= 4'd1 && cause <= 4'd3));

  a_r7_shrink_code: assert property (@(posedge clk) disable iff (!rst_n)
    (change && level > $past(level)) |-> (cause >= 4'd4 && cause <= 4'd8));
endmodule

bind iq_window_monitor iq_window_monitor_chk #(.WIN_BITS(WIN_BITS), .MAX_LEVEL(MAX_LEVEL)) chk_i (
  .clk(clk), .rst_n(rst_n), .level(level), .change(change), .cause(cause), .win_cnt(win_cnt)
);

// File: tb/iq_window_monitor_tb_top.sv
`timescale 1ns/1ps
module iq_window_monitor_tb_top;
  localparam int WB = 10;
  localparam int W  = 1 << WB;
  localparam int MAXL = 3;
  localparam int SH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] issue_cnt = '0, commit_cnt = '0, stall_cnt = '0, ready_cnt = '0;
  logic [6:0] occupancy = '0;
  logic [1:0] level;
  logic       change;
  logic [3:0] cause;

  always #5 clk = ~clk;

  iq_window_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .issue_cnt(issue_cnt), .commit_cnt(commit_cnt),
    .stall_cnt(stall_cnt), .ready_cnt(ready_cnt), .occupancy(occupancy),
    .level(level), .change(change), .cause(cause)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit pend_low = 0;
  int    q_lvl[$];
  int    q_cause[$];
  int    q_chg[$];
  string q_tag[$];

  longint m_lvl, m_prev, m_full, m_avgi, m_avgo;

  task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lvl = 0; m_prev = 0; m_full = 0; m_avgi = 0; m_avgo = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    issue_cnt = '0; commit_cnt = '0; stall_cnt = '0; ready_cnt = '0; occupancy = '0;
    repeat (3) @(negedge clk);
    q_lvl.delete(); q_cause.delete(); q_chg.delete(); q_tag.delete();
    pend_low = 0;
    model_reset();
    check(level == 0, "R1", "reset level", level, 0);
    check(cause == 0, "R1", "reset cause", cause, 0);
    check(change == 0, "R1", "reset change", change, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_window(input int i, input int ix, input int c, input int s,
                            input int r, input int o, input string tag);
    longint ti, tc, ts, tr, to, th, nl;
    bit g1, g2, g3, s1, s2, s3, s4, s5;
    int cz;
    for (int k = 0; k < W; k++) begin
      issue_cnt  = 4'(i + ((k < ix) ? 1 : 0));
      commit_cnt = 4'(c);
      stall_cnt  = 4'(s);
      ready_cnt  = 4'(r);
      occupancy  = 7'(o);
      @(negedge clk);
    end
    ti = longint'(i) * W + ix; tc = longint'(c) * W; ts = longint'(s) * W;
    tr = longint'(r) * W;      to = longint'(o) * W;
    g1 = 100 * ti < 92 * m_prev;
    g2 = 100 * ti < 94 * m_full;
    g3 = 100 * ts > 15 * tr;
    s1 = ti > tc + W;
    s2 = 100 * ts < 3 * tr;
    th = (2 * m_lvl >= 27) ? 0 : 27 - 2 * m_lvl;
    s3 = 10 * ti < th * W;
    s4 = 5 * to < m_avgo;
    s5 = 100 * m_avgi > 100 * ti + 15 * (m_lvl + 1) * W;
    cz = g1 ? 1 : g2 ? 2 : g3 ? 3 : s1 ? 4 : s2 ? 5 : s3 ? 6 : s4 ? 7 : s5 ? 8 : 0;
    nl = m_lvl;
    if (cz >= 1 && cz <= 3) begin if (m_lvl > 0) nl = m_lvl - 1; end
    else if (cz >= 4) begin if (m_lvl < MAXL) nl = m_lvl + 1; end
    m_prev = ti;
    if (m_lvl == 0) m_full = ti;
    m_avgi = m_avgi - (m_avgi >> SH) + (ti >> SH);
    m_avgo = m_avgo - (m_avgo >> SH) + (to >> SH);
    q_lvl.push_back(int'(nl));
    q_cause.push_back(cz);
    q_chg.push_back((nl != m_lvl) ? 1 : 0);
    q_tag.push_back(tag);
    m_lvl = nl;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (pend_low) begin
        check(change == 0, "R3", "pulse still high", change, 0);
        pend_low = 0;
      end
      if (q_lvl.size() > 0) begin
        int el, ec, eg;
        string t;
        el = q_lvl.pop_front(); ec = q_cause.pop_front();
        eg = q_chg.pop_front(); t = q_tag.pop_front();
        check(int'(level) == el, t, "level", level, el);
        check(int'(cause) == ec, t, "cause", cause, ec);
        check(int'(change) == eg, "R3", "change pulse", change, eg);
        pend_low = 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: quiet windows keep level 0 with no rule firing
    do_reset();
    run_window(3, 0, 3, 1, 10, 40, "R1");
    run_window(3, 0, 3, 1, 10, 40, "R1");
    // R4 code 5, then R2 stepping and R8 saturation at MAX_LEVEL
    do_reset();
    run_window(3, 0, 3, 1, 10, 40, "R1");
    run_window(3, 0, 3, 0, 10, 40, "R4");
    run_window(3, 0, 3, 0, 10, 40, "R2");
    run_window(3, 0, 3, 0, 10, 40, "R2");
    run_window(3, 0, 3, 0, 10, 40, "R8");
    // R4 code 4, then R7 grow beats shrink with code 3 (R6)
    do_reset();
    run_window(5, 0, 3, 1, 10, 40, "R4");
    run_window(5, 0, 3, 2, 10, 40, "R7");
    // R5 rate threshold moves with level
    do_reset();
    run_window(2, 410, 2, 1, 10, 40, "R5");
    run_window(2, 410, 2, 1, 10, 40, "R5");
    run_window(2, 410, 2, 1, 10, 40, "R5");
    // R9 occupancy average, code 7
    do_reset();
    for (int n = 0; n < 4; n++) run_window(3, 0, 3, 1, 10, 40, "R9");
    run_window(3, 0, 3, 1, 10, 2, "R9");
    // R9/R5 issue average margin, code 8; then R6 codes 2 and 1, R8 at level 0
    do_reset();
    for (int n = 0; n < 20; n++) run_window(4, 0, 4, 1, 10, 40, "R9");
    run_window(3, 800, 3, 1, 10, 40, "R5");
    run_window(3, 528, 3, 1, 10, 40, "R6");
    run_window(3, 0, 3, 1, 10, 40, "R8");
    @(negedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule